// File: doc/BRIEF.md
# Triggered Capture Buffer

This block is an on-chip logic-analyzer core. On every clock where the sample enable is high it stores one 32-bit word into a circular memory of `2**ADDR_LG` entries. It sits on a simple pipelined register bus with two addresses. Address 0 holds control and status. Address 1 is the data port.

A run starts when software writes address 0 with the keep bit clear. The core first fills every memory location. It then waits for a trigger, either the external trigger pin or a pending manual trigger. After the trigger it stores a programmed number of further samples (the holdoff) and then stops capturing. Software reads the data port repeatedly while the core is stopped. Each read returns the next stored sample, beginning with the oldest. The interrupt line stays high for as long as the core is stopped.

The state machine has four states:
- FILL: the memory is not yet full.
- ARMED: the memory is full and the core is waiting for a trigger.
- HOLDOFF: the core has triggered and is counting post-trigger samples.
- DONE: capture has ceased.

It has these transitions:
- Any state goes to FILL on a reset command.
- FILL goes to ARMED on the enabled sample written into the last memory location.
- ARMED goes to HOLDOFF on a trigger when the holdoff is non-zero. It goes straight to DONE on a trigger when the holdoff is zero.
- HOLDOFF goes to DONE on the enabled sample that completes the holdoff count.
- DONE stays in DONE until the next reset command.

Top module: `capture_scope`

## Requirements
- R1: A write to address 0 with bit 31 (keep) clear is a reset command. Whatever the state, it moves the core to FILL, empties the buffer and drops `irq`. It also zeroes the readback position, loads the holdoff from bits [HOLD_W-1:0], loads the disable flag from bit 29 and loads the manual-trigger pending flag from bit 30. No sample is stored on that cycle.
- R2: A sample is stored only on a cycle with `smp_en` high, and never while the core is in DONE.
- R3: The core reaches ARMED only after `2**ADDR_LG` enabled samples have been stored since the last reset. Triggers seen during FILL are ignored.
- R4: In ARMED, an enabled sample with `trig_in` high, and with the disable flag clear, is the trigger sample. After it the core stores exactly holdoff further enabled samples and then enters DONE.
- R5: With holdoff 0, the newest stored sample is the trigger sample. With holdoff `2**ADDR_LG - 1`, the oldest stored sample is the trigger sample.
- R6: A manual-trigger request given with a reset command makes the first enabled sample after ARMED is reached the trigger sample.
- R7: A write to address 0 with bit 31 set leaves the capture state and buffer intact. If its bit 30 is set, the next enabled sample in ARMED is the trigger sample.
- R8: While the disable flag is set, `trig_in` never triggers the core.
- R9: Each read of address 1 in DONE returns the next stored sample, starting with the oldest. After the newest, it wraps to the oldest.
- R10: A read of address 0 returns the status word. Bit 31 is FILL. Bit 30 is manual pending. Bit 29 is disable. Bit 28 is DONE. Bit 27 is triggered (HOLDOFF or DONE). Bit 26 is primed (any state but FILL). Bits [HOLD_W-1:0] are the holdoff, and the other bits are zero.
- R11: `irq` is high exactly while the core is in DONE.
- R12: `bus_ack` is high on the cycle after every strobe with `bus_cyc`, and read data is valid alongside it. `bus_stall` is always 0. Back-to-back reads are accepted on consecutive cycles.
- R13: After `rst_n`, the core is in FILL with holdoff 0 and disable, manual and `irq` all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling and bus |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample enable |
| smp_data | input | 32 | Word to record |
| trig_in | input | 1 | External trigger |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 1 | 0 selects control/status, 1 selects data port |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | Acknowledge, one cycle after strobe |
| bus_stall | output | 1 | Always 0 |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| irq | output | 1 | High while stopped |

## Verification
Each state change, including entry to DONE and the rise of `irq`, takes effect at the clock edge that consumes the deciding enabled sample or control write. Acknowledge and read data appear one edge after the strobe. The bench drives inputs on falling edges and updates its queue-based model at each rising edge, using the values that were driven. It compares `irq`, `bus_ack`, `bus_stall` and any due read data at the following falling edge. Scenario checks then confirm the trigger-sample position, the oldest-first readback, the buffer staying frozen after stop, and the status word, each at that same half-cycle offset.

// File: rtl/scope_pkg.sv
package scope_pkg;

    // Capture states, in the order a run passes through them
    typedef enum logic [1:0] {
        ST_FILL    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HOLDOFF = 2'd2,
        ST_DONE    = 2'd3
    } scope_state_e;

    // Command bits of a control write
    localparam int CMD_KEEP = 31;
    localparam int CMD_MAN  = 30;
    localparam int CMD_DIS  = 29;

    // Status word bit positions
    localparam int STS_FILL  = 31;
    localparam int STS_MAN   = 30;
    localparam int STS_DIS   = 29;
    localparam int STS_DONE  = 28;
    localparam int STS_TRIG  = 27;
    localparam int STS_ARMED = 26;

endpackage

// File: rtl/scope_mem.sv
module scope_mem #(
    parameter int DATA_W  = 32,
    parameter int ADDR_LG = 5
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_LG-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_word,
    input  logic [ADDR_LG-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_word
);
    localparam int DEPTH = 1 << ADDR_LG;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write port: one sample per enabled cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_word;
        end
    end

    // Registered read port, read-before-write
    always_ff @(posedge clk) begin
        rd_q <= store[rd_addr];
    end

    assign rd_word = rd_q;

endmodule

// File: rtl/scope_ctrl.sv
module scope_ctrl
    import scope_pkg::*;
#(
    parameter int ADDR_LG = 5,
    parameter int HOLD_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_en,
    input  logic               trig_in,
    input  logic               cmd_rst,
    input  logic               cmd_man,
    input  logic               dis_trig,
    input  logic [HOLD_W-1:0]  holdoff,
    input  logic               rd_adv,
    output scope_state_e       state,
    output logic               man_pend,
    output logic               mem_we,
    output logic [ADDR_LG-1:0] wr_ptr,
    output logic [ADDR_LG-1:0] rd_addr,
    output logic               irq
);
    localparam logic [ADDR_LG-1:0] LAST_SLOT = {ADDR_LG{1'b1}};

    scope_state_e       state_q, state_d;
    logic [ADDR_LG-1:0] wr_q;
    logic [ADDR_LG-1:0] rd_off_q;
    logic [HOLD_W-1:0]  hcnt_q;
    logic               man_q;
    logic               fire;
    logic               cap;

    // Trigger decision for this cycle
    assign fire = smp_en && ((trig_in && !dis_trig) || man_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (smp_en && (wr_q == LAST_SLOT)) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (fire) begin
                    state_d = (holdoff == '0) ? ST_DONE : ST_HOLDOFF;
                end
            end
            ST_HOLDOFF: begin
                if (smp_en && ((hcnt_q + 1'b1) == holdoff)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
        endcase
        if (cmd_rst) begin
            state_d = ST_FILL;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Counters and pending manual trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_off_q <= '0;
            hcnt_q   <= '0;
            man_q    <= 1'b0;
        end else begin
            if (cmd_rst) begin
                wr_q <= '0;
            end else if (cap) begin
                wr_q <= wr_q + 1'b1;
            end

            if (cmd_rst) begin
                rd_off_q <= '0;
            end else if (rd_adv && (state_q == ST_DONE)) begin
                rd_off_q <= rd_off_q + 1'b1;
            end

            if (cmd_rst || (state_q == ST_ARMED)) begin
                hcnt_q <= '0;
            end else if ((state_q == ST_HOLDOFF) && smp_en) begin
                hcnt_q <= hcnt_q + 1'b1;
            end

            if (cmd_rst) begin
                man_q <= cmd_man;
            end else if (cmd_man) begin
                man_q <= 1'b1;
            end else if ((state_q == ST_ARMED) && fire) begin
                man_q <= 1'b0;
            end
        end
    end

    // Output decode
    always_comb begin
        cap      = smp_en && !cmd_rst && (state_q != ST_DONE);
        mem_we   = cap;
        wr_ptr   = wr_q;
        rd_addr  = wr_q + rd_off_q;
        irq      = (state_q == ST_DONE);
        state    = state_q;
        man_pend = man_q;
    end

    AST_RESET_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (state_q == ST_FILL)); // R1
    AST_FILL_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> (state_q == ST_FILL || state_q == ST_ARMED)); // R3
    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !cmd_rst) |=> (state_q == ST_DONE && $stable(wr_q))); // R2
    AST_ZERO_HOLD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && fire && holdoff == '0 && !cmd_rst) |=> (state_q == ST_DONE)); // R5
    AST_DISABLED_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && dis_trig && !man_q && !cmd_rst) |=> (state_q == ST_ARMED)); // R8
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && rd_adv && !cmd_rst)
            |=> (rd_off_q == ADDR_LG'($past(rd_off_q) + 1'b1))); // R9

endmodule

// File: rtl/scope_bus.sv
module scope_bus
    import scope_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int HOLD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  mem_word,
    input  scope_state_e      state,
    input  logic              man_pend,
    output logic              bus_ack,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [HOLD_W-1:0] holdoff,
    output logic              dis_trig,
    output logic              cmd_rst,
    output logic              cmd_man,
    output logic              rd_adv
);
    logic              req;
    logic              ctrl_wr;
    logic              ack_q;
    logic              addr_q;
    logic [BUS_W-1:0]  stat_q;
    logic [BUS_W-1:0]  stat_now;
    logic [HOLD_W-1:0] hold_q;
    logic              dis_q;

    // Command decode
    always_comb begin
        req     = bus_cyc && bus_stb;
        ctrl_wr = req && bus_we && !bus_addr;
        cmd_rst = ctrl_wr && !bus_wdata[CMD_KEEP];
        cmd_man = ctrl_wr && bus_wdata[CMD_MAN];
        rd_adv  = req && !bus_we && bus_addr;
    end

    // Status word assembly
    always_comb begin
        stat_now                 = '0;
        stat_now[HOLD_W-1:0]     = hold_q;
        stat_now[STS_FILL]       = (state == ST_FILL);
        stat_now[STS_MAN]        = man_pend;
        stat_now[STS_DIS]        = dis_q;
        stat_now[STS_DONE]       = (state == ST_DONE);
        stat_now[STS_TRIG]       = (state == ST_HOLDOFF) || (state == ST_DONE);
        stat_now[STS_ARMED]      = (state != ST_FILL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            addr_q <= 1'b0;
            stat_q <= '0;
            hold_q <= '0;
            dis_q  <= 1'b0;
        end else begin
            ack_q  <= req;
            addr_q <= bus_addr;
            stat_q <= stat_now;
            if (ctrl_wr) begin
                hold_q <= bus_wdata[HOLD_W-1:0];
                dis_q  <= bus_wdata[CMD_DIS];
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = addr_q ? mem_word : stat_q;
    assign holdoff   = hold_q;
    assign dis_trig  = dis_q;

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> bus_ack); // R12
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !bus_ack); // R12

endmodule

// File: rtl/capture_scope.sv
module capture_scope
    import scope_pkg::*;
#(
    parameter int ADDR_LG = 5,
    parameter int HOLD_W  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_en,
    input  logic [31:0] smp_data,
    input  logic        trig_in,
    input  logic        bus_cyc,
    input  logic        bus_stb,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic        bus_stall,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int BUS_W = 32;

    scope_state_e       state;
    logic               man_pend;
    logic               mem_we;
    logic [ADDR_LG-1:0] wr_ptr;
    logic [ADDR_LG-1:0] rd_addr;
    logic [BUS_W-1:0]   mem_word;
    logic [HOLD_W-1:0]  holdoff;
    logic               dis_trig;
    logic               cmd_rst;
    logic               cmd_man;
    logic               rd_adv;

    scope_bus #(.BUS_W(BUS_W), .HOLD_W(HOLD_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mem_word  (mem_word),
        .state     (state),
        .man_pend  (man_pend),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .holdoff   (holdoff),
        .dis_trig  (dis_trig),
        .cmd_rst   (cmd_rst),
        .cmd_man   (cmd_man),
        .rd_adv    (rd_adv)
    );

    scope_ctrl #(.ADDR_LG(ADDR_LG), .HOLD_W(HOLD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .trig_in  (trig_in),
        .cmd_rst  (cmd_rst),
        .cmd_man  (cmd_man),
        .dis_trig (dis_trig),
        .holdoff  (holdoff),
        .rd_adv   (rd_adv),
        .state    (state),
        .man_pend (man_pend),
        .mem_we   (mem_we),
        .wr_ptr   (wr_ptr),
        .rd_addr  (rd_addr),
        .irq      (irq)
    );

    scope_mem #(.DATA_W(BUS_W), .ADDR_LG(ADDR_LG)) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (wr_ptr),
        .wr_word (smp_data),
        .rd_addr (rd_addr),
        .rd_word (mem_word)
    );

    assign bus_stall = 1'b0;

endmodule

// File: tb/capture_scope_tb.sv
`timescale 1ns/1ps
module capture_scope_tb;
    localparam int ADDR_LG = 5;
    localparam int HOLD_W  = 20;
    localparam int DEPTH   = 1 << ADDR_LG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [31:0] smp_data = '0;
    logic        trig_in = 1'b0;
    logic        b_cyc = 1'b0, b_stb = 1'b0, b_we = 1'b0, b_addr = 1'b0;
    logic [31:0] b_wd = '0;
    logic        bus_ack, bus_stall, irq;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    capture_scope #(.ADDR_LG(ADDR_LG), .HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
        .trig_in(trig_in), .bus_cyc(b_cyc), .bus_stb(b_stb), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wd), .bus_ack(bus_ack),
        .bus_stall(bus_stall), .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Behavioural reference model
    logic [31:0] mq[$];
    int m_state = 0;   // 0 fill, 1 armed, 2 holdoff, 3 done
    int m_hold = 0, m_cnt = 0, m_rd = 0;
    bit m_dis = 0, m_man = 0;
    bit m_ack = 0, m_chk = 0;
    logic [31:0] m_exp = '0;
    string m_tag = "";
    logic [31:0] rbuf [64];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[HOLD_W-1:0] = m_hold[HOLD_W-1:0];
        s[31] = (m_state == 0);
        s[30] = m_man;
        s[29] = m_dis;
        s[28] = (m_state == 3);
        s[27] = (m_state >= 2);
        s[26] = (m_state >= 1);
        return s;
    endfunction

    task automatic model_edge();
        bit cw = b_cyc && b_stb && b_we && !b_addr;
        bit rr = b_cyc && b_stb && !b_we;
        m_ack = b_cyc && b_stb;
        m_chk = 0;
        if (!rst_n) begin
            m_state = 0; m_hold = 0; m_dis = 0; m_man = 0; m_rd = 0; m_ack = 0;
            mq.delete();
            return;
        end
        if (rr) begin
            if (!b_addr) begin
                m_exp = m_status(); m_chk = 1; m_tag = "R10";
            end else if (m_state == 3) begin
                m_exp = mq[m_rd]; m_chk = 1; m_tag = "R9";
                m_rd = (m_rd + 1) % DEPTH;
            end
        end
        if (cw && !b_wd[31]) begin
            m_state = 0; m_rd = 0; mq.delete();
            m_man = b_wd[30];
            m_hold = int'(b_wd[HOLD_W-1:0]); m_dis = b_wd[29];
        end else begin
            if (smp_en && m_state != 3) begin
                mq.push_back(smp_data);
                if (mq.size() > DEPTH) void'(mq.pop_front());
                case (m_state)
                    0: if (mq.size() == DEPTH) m_state = 1;
                    1: if ((trig_in && !m_dis) || m_man) begin
                           m_man = 0; m_cnt = 0;
                           m_state = (m_hold == 0) ? 3 : 2;
                       end
                    2: begin
                           m_cnt++;
                           if (m_cnt == m_hold) m_state = 3;
                       end
                    default: ;
                endcase
            end
            if (cw) begin
                m_hold = int'(b_wd[HOLD_W-1:0]); m_dis = b_wd[29];
                if (b_wd[30]) m_man = 1;
            end
        end
    endtask

    // One clock: model at rising edge, compare at falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R12 ack", {31'b0, bus_ack}, {31'b0, m_ack});
        check("R12 stall", {31'b0, bus_stall}, 32'd0);
        check("R11 irq", {31'b0, irq}, {31'b0, m_state == 3});
        if (m_chk && bus_ack) check(m_tag, bus_rdata, m_exp);
    endtask

    task automatic idle();
        smp_en = 0; trig_in = 0; b_cyc = 0; b_stb = 0; b_we = 0;
        step();
    endtask

    task automatic bus_write(input logic [31:0] v);
        smp_en = 0; trig_in = 0;
        b_cyc = 1; b_stb = 1; b_we = 1; b_addr = 0; b_wd = v;
        step();
        b_cyc = 0; b_stb = 0; b_we = 0;
    endtask

    // Back-to-back reads, one per cycle
    task automatic burst_read(input logic a, input int n);
        smp_en = 0; trig_in = 0;
        for (int i = 0; i < n; i++) begin
            b_cyc = 1; b_stb = 1; b_we = 0; b_addr = a;
            step();
            rbuf[i] = bus_rdata;
        end
        b_cyc = 0; b_stb = 0;
    endtask

    task automatic sample(input logic [31:0] d, input bit t);
        smp_en = 1; smp_data = d; trig_in = t;
        step();
        smp_en = 0; trig_in = 0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1;
        idle();
        // R13 reset state
        burst_read(0, 1);
        check("R13 status after reset", rbuf[0], 32'h8000_0000);
        check("R13 irq after reset", {31'b0, irq}, 32'd0);

        // Scenario A: holdoff 3, trigger in fill ignored, gaps with trigger but no enable
        bus_write(32'd3);
        for (int i = 0; i < 40; i++) begin
            if (i == 20) begin
                smp_en = 0; trig_in = 1; step(); trig_in = 0;   // R2 no enable
            end
            sample(100 + i, (i == 5) || (i == 35));
        end
        check("R4 irq after holdoff", {31'b0, irq}, 32'd1);
        burst_read(0, 1);
        check("R10 status stopped", rbuf[0], 32'h1C00_0003);
        burst_read(1, 33);
        check("R9 oldest first", rbuf[0], 32'd107);
        check("R4 trigger position", rbuf[28], 32'd135);
        check("R9 wrap to oldest", rbuf[32], 32'd107);
        check("R3 fill trigger ignored newest", rbuf[31], 32'd138);

        // Scenario B: holdoff 0, trigger is newest
        bus_write(32'd0);
        check("R1 irq cleared by reset", {31'b0, irq}, 32'd0);
        for (int i = 0; i < 33; i++) sample(200 + i, i == 32);
        for (int i = 0; i < 3; i++) sample(250 + i, 1'b0);
        burst_read(1, 32);
        check("R5 hold0 newest is trigger", rbuf[31], 32'd232);
        burst_read(1, 1);
        check("R2 frozen after stop", rbuf[0], 32'd201);

        // Scenario C: holdoff depth-1, trigger is oldest
        bus_write(DEPTH - 1);
        for (int i = 0; i < 64; i++) sample(300 + i, i == 32);
        burst_read(1, 2);
        check("R5 max hold oldest is trigger", rbuf[0], 32'd332);

        // Scenario D: manual trigger with reset
        bus_write(32'h4000_0002);
        burst_read(0, 1);
        check("R6 manual pending", rbuf[0], 32'hC000_0002);
        for (int i = 0; i < 34; i++) sample(400 + i, 1'b0);
        check("R6 not yet stopped", {31'b0, irq}, 32'd0);
        sample(434, 1'b0);
        check("R6 stopped", {31'b0, irq}, 32'd1);
        burst_read(1, 1);
        check("R6 oldest", rbuf[0], 32'd403);

        // Scenario E: disable blocks external trigger, keep+manual fires
        bus_write(32'h2000_0001);
        for (int i = 0; i < 40; i++) sample(500 + i, 1'b1);
        check("R8 disabled no stop", {31'b0, irq}, 32'd0);
        bus_write(32'hE000_0001);
        sample(600, 1'b0);
        check("R7 holdoff after manual", {31'b0, irq}, 32'd0);
        sample(601, 1'b0);
        check("R7 keep manual stops", {31'b0, irq}, 32'd1);
        burst_read(1, 32);
        check("R7 buffer kept", rbuf[0], 32'd510);
        check("R7 newest", rbuf[31], 32'd601);

        // R1 reset from DONE
        bus_write(32'd0);
        idle();
        burst_read(0, 1);
        check("R1 status after reset cmd", rbuf[0], 32'h8000_0000);
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule